// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge-Select Interrupts

This block is a 16-bit general-purpose I/O port that sits behind a simple register bus and takes only 16-bit accesses. Each pin can be an output or an input. Output pins are driven from an output latch, and each has its own output enable. Input pins are sampled through a two-flop synchronizer. An edge on an input pin can latch a sticky status bit. One register bit per pin picks whether that pin reacts to a rising edge or a falling edge.

A per-pin mask can block interrupts, and software clears status by writing ones to it. A single registered interrupt line is high while any status bit is set. When the data-input register is read, the synchronized sample is ANDed with a pin-enable register.

Seven halfword registers are mapped at word-aligned offsets, with the register index in address bits [4:2]:

| Offset | Register | Access |
|---|---|---|
| 0x00 | pin sample | read-only |
| 0x04 | output latch | read/write |
| 0x08 | direction | read/write |
| 0x0C | edge select | read/write |
| 0x10 | mask | read/write |
| 0x14 | status | write 1 to clear |
| 0x18 | pin enable | read/write |

Top module: `gpio16_port`

## Requirements
- R1: After reset, the output latch, direction, edge-select, mask and pin-enable registers read 0xFFFF, and the status and pin-sample registers read 0. After reset, `pinOe` is 0, `pinOut` is 0xFFFF and `irqOut` is 0.
- R2: A direction bit of 1 makes the pin an input. `pinOe` is the inverse of the direction register and `pinOut` is the output latch. Both update on the clock edge that accepts the write.
- R3: When a pin's edge-select bit is 1, a rising transition of its synchronized input sets its status bit.
- R4: When a pin's edge-select bit is 0, a falling transition sets its status bit. A transition in the other direction does not.
- R5: A transition sets a status bit only while the pin's direction bit is 1 and its mask bit is 0.
- R6: Writing the status register (offset 0x14) clears every bit written as 1. `irqOut` is a register that holds the OR of the status bits, one cycle behind them.
- R7: If a status bit is set by an edge and cleared by a write in the same cycle, it stays set.
- R8: Reading offset 0x00 returns the synchronized input ANDed with the pin-enable register (offset 0x18). An input change reaches that read after two clock edges.
- R9: An access with `busSize` other than 2'b01 (halfword) is ignored. It writes nothing and leaves `busRdata` unchanged.
- R10: Writes to offset 0x00 have no effect. Accesses to an unmapped offset are ignored: this covers a misaligned offset, an offset above 0x18, and any offset with a nonzero address bit above bit 4.
- R11: `busRdata` takes the addressed register's value on the clock edge that accepts a read, and holds that value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access width code; 2'b01 = halfword |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | PIN_W | Write data |
| busRdata | output | PIN_W | Registered read data |
| pinIn | input | PIN_W | Asynchronous pin inputs |
| pinOut | output | PIN_W | Output latch value |
| pinOe | output | PIN_W | Per-pin output enable |
| irqOut | output | 1 | Level interrupt |

## Verification
The edge detector is tested on each mode separately:
- a rising edge on a pin set to rising,
- a rising and then a falling edge on a pin set to falling,
- an edge on a pin configured as an output,
- an edge on a masked pin.

This set tells a correct polarity select apart from an inverted or ignored one, and shows that the direction gate and the mask gate each work on their own. The pin-sample register is read at two different pin-enable values, and once only one cycle after an input change, which shows the enable gating and the synchronizer depth. The status clear is timed to land on the same edge as a new event, which tells set-wins from clear-wins. Narrow, misaligned, unmapped and read-only accesses are each followed by readbacks at the ports.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

  localparam logic [1:0] SIZE_HALF = 2'b01;

  // Register index taken from address bits [4:2]; index 7 means no register selected.
  typedef enum logic [2:0] {
    SEL_DIN  = 3'd0,
    SEL_DOUT = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_EDGE = 3'd3,
    SEL_MASK = 3'd4,
    SEL_STAT = 3'd5,
    SEL_PEN  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
  } busStrobe_t;

endpackage

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
  import gpio16_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEL_PEN);

  logic [IDX_W-1:0] idx;
  logic aligned, inRange, sizeOk, accept;

  assign idx     = busAddr[IDX_MSB:IDX_LSB];
  assign aligned = (busAddr[IDX_LSB-1:0] == '0);
  assign inRange = ((busAddr >> (IDX_MSB + 1)) == '0) && (idx <= LAST_IDX);
  assign sizeOk  = (busSize == SIZE_HALF);
  assign accept  = busReq && aligned && inRange && sizeOk;

  assign strobe.sel  = accept ? regSel_e'(idx) : SEL_NONE;
  assign strobe.wrEn = accept && busWe && (idx != IDX_W'(SEL_DIN));
  assign strobe.rdEn = accept && !busWe;

endmodule

// File: rtl/gpio16_dp.sv
module gpio16_dp
  import gpio16_pkg::*;
#(
  parameter int PIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] rdData,
  output logic             irqOut
);

  localparam logic [PIN_W-1:0] ALL_ONES = '1;
  localparam logic [PIN_W-1:0] ALL_ZERO = '0;

  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;
  logic [PIN_W-1:0] sample, prevQ;
  logic [PIN_W-1:0] outQ, dirQ, edgeQ, maskQ, statQ, penQ, rdQ;
  logic [PIN_W-1:0] rise, fall, hit, clrBits, rdMux;
  logic irqQ;

  assign sample = syncQ[SYNC_STAGES-1];
  assign rise   = sample & ~prevQ;
  assign fall   = ~sample & prevQ;
  // An edge counts only on an input pin whose mask bit is clear.
  assign hit    = ((edgeQ & rise) | (~edgeQ & fall)) & dirQ & ~maskQ;
  assign clrBits = (strobe.wrEn && strobe.sel == SEL_STAT) ? wrData : ALL_ZERO;

  always_comb begin
    case (strobe.sel)
      SEL_DIN:  rdMux = sample & penQ;
      SEL_DOUT: rdMux = outQ;
      SEL_DIR:  rdMux = dirQ;
      SEL_EDGE: rdMux = edgeQ;
      SEL_MASK: rdMux = maskQ;
      SEL_STAT: rdMux = statQ;
      SEL_PEN:  rdMux = penQ;
      default:  rdMux = rdQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= ALL_ZERO;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= sample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= ALL_ONES;
      dirQ  <= ALL_ONES;
      edgeQ <= ALL_ONES;
      maskQ <= ALL_ONES;
      penQ  <= ALL_ONES;
      statQ <= ALL_ZERO;
      rdQ   <= ALL_ZERO;
      irqQ  <= 1'b0;
    end else begin
      if (strobe.wrEn && strobe.sel == SEL_DOUT) outQ  <= wrData;
      if (strobe.wrEn && strobe.sel == SEL_DIR)  dirQ  <= wrData;
      if (strobe.wrEn && strobe.sel == SEL_EDGE) edgeQ <= wrData;
      if (strobe.wrEn && strobe.sel == SEL_MASK) maskQ <= wrData;
      if (strobe.wrEn && strobe.sel == SEL_PEN)  penQ  <= wrData;
      // New events are ORed in after the clear, so an event wins over a clear in the same cycle.
      statQ <= (statQ & ~clrBits) | hit;
      irqQ  <= |statQ;
      if (strobe.rdEn) rdQ <= rdMux;
    end
  end

  assign pinOut = outQ;
  assign pinOe  = ~dirQ;
  assign rdData = rdQ;
  assign irqOut = irqQ;

endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
  import gpio16_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irqOut
);

  busStrobe_t strobe;

  gpio16_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busReq (busReq),
    .busWe  (busWe),
    .busSize(busSize),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio16_dp #(.PIN_W(PIN_W), .SYNC_STAGES(2)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(busWdata),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .rdData(busRdata),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk #(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic [1:0]        busSize,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PIN_W-1:0]  busWdata,
  input logic [PIN_W-1:0]  busRdata,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOe,
  input logic              irqOut
);

  logic halfWr;
  assign halfWr = busReq && busWe && (busSize == 2'b01);

  // R2
  a_r2_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && busAddr == ADDR_W'(8)) |=> (pinOe == ~$past(busWdata)));

  // R2
  a_r2_out_tracks_latch: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && busAddr == ADDR_W'(4)) |=> (pinOut == $past(busWdata)));

  // R9
  a_r9_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busSize != 2'b01) |=> ($stable(pinOut) && $stable(pinOe)));

  // R11
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && !busWe) |=> $stable(busRdata));

  // R6
  a_r6_irq_falls_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(halfWr && busAddr == ADDR_W'(20), 2));

endmodule

bind gpio16_port gpio16_port_chk #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busReq  (busReq),
  .busWe   (busWe),
  .busSize (busSize),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqOut  (irqOut)
);

// File: tb/gpio16_port_bench.sv
`timescale 1ns/1ps
module gpio16_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busSize = 2'b01;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] pins = '0;
  logic [15:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  gpio16_port u_gpio16_port (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pins), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [15:0] data,
                          input logic [1:0] size = 2'b01);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = addr; busWdata = data; busSize = size;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0; busSize = 2'b01;
  endtask

  // Driver: issues the read and queues the value the monitor must see.
  task automatic busRead(input logic [7:0] addr, input logic [15:0] exp, input string tag,
                         input logic [1:0] size = 2'b01);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = addr; busSize = size;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busReq = 1'b0; busSize = 2'b01;
  endtask

  // Monitor: compares the read data shortly after the edge that captured it.
  always @(posedge clk) begin
    if (rstN && busReq && !busWe) begin
      #2;
      if (expQ.size() > 0) check(tagQ.pop_front(), busRdata, expQ.pop_front());
      else begin checks++; errors++; $display("FAIL R11 actual unexpected read expected none"); end
    end
  end

  task automatic setPins(input logic [15:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    check("R1 pinOut", pinOut, 16'hFFFF);
    check("R1 pinOe", pinOe, 16'h0000);
    check("R1 irqOut", {15'd0, irqOut}, 16'h0000);
    busRead(8'h08, 16'hFFFF, "R1 dir");
    busRead(8'h0C, 16'hFFFF, "R1 edge");
    busRead(8'h10, 16'hFFFF, "R1 mask");
    busRead(8'h18, 16'hFFFF, "R1 pen");
    busRead(8'h14, 16'h0000, "R1 status");
    busRead(8'h00, 16'h0000, "R1 sample");
    // R2 direction and output latch
    busWrite(8'h04, 16'h00A5);
    check("R2 pinOut", pinOut, 16'h00A5);
    busWrite(8'h08, 16'hFF00);
    check("R2 pinOe", pinOe, 16'h00FF);
    busRead(8'h04, 16'h00A5, "R2 latch readback");
    // R8 pin sample gating and synchronizer depth
    @(negedge clk); pins = 16'h1234;
    repeat (3) @(negedge clk);
    busRead(8'h00, 16'h1234, "R8 sample");
    busWrite(8'h18, 16'h00FF);
    busRead(8'h00, 16'h0034, "R8 gated");
    @(negedge clk); pins = 16'hFFFF;
    busRead(8'h00, 16'h0034, "R8 two-stage latency");
    repeat (3) @(negedge clk);
    busRead(8'h00, 16'h00FF, "R8 after sync");
    busWrite(8'h18, 16'hFFFF);
    setPins(16'h0000);
    // arm interrupts
    busWrite(8'h10, 16'h0000);
    busWrite(8'h0C, 16'h0F00);
    busRead(8'h14, 16'h0000, "R5 masked edges left no status");
    // R3 rising edge
    setPins(16'h0100);
    busRead(8'h14, 16'h0100, "R3 rising sets status");
    check("R6 irq high", {15'd0, irqOut}, 16'h0001);
    // R4 falling mode
    setPins(16'h1100);
    busRead(8'h14, 16'h0100, "R4 rise ignored in falling mode");
    setPins(16'h0100);
    busRead(8'h14, 16'h1100, "R4 falling sets status");
    // R5 output pin and masked pin
    setPins(16'h0101);
    setPins(16'h0100);
    busRead(8'h14, 16'h1100, "R5 output pin ignored");
    busWrite(8'h10, 16'h0200);
    setPins(16'h0300);
    busRead(8'h14, 16'h1100, "R5 masked pin ignored");
    // R6 write-one-to-clear and irq
    busWrite(8'h14, 16'h0100);
    busRead(8'h14, 16'h1000, "R6 partial clear");
    check("R6 irq stays high", {15'd0, irqOut}, 16'h0001);
    busWrite(8'h14, 16'h1000);
    check("R6 irq lags status", {15'd0, irqOut}, 16'h0001);
    @(negedge clk);
    check("R6 irq low", {15'd0, irqOut}, 16'h0000);
    busRead(8'h14, 16'h0000, "R6 status empty");
    // R7 set wins over clear in the same cycle
    @(negedge clk); pins = 16'h0700;
    @(negedge clk);
    busWrite(8'h14, 16'h0400);
    busRead(8'h14, 16'h0400, "R7 set wins");
    check("R7 irq", {15'd0, irqOut}, 16'h0001);
    busWrite(8'h14, 16'hFFFF);
    // R9 narrow accesses
    busWrite(8'h04, 16'h0000, 2'b10);
    check("R9 wide write ignored", pinOut, 16'h00A5);
    busWrite(8'h08, 16'h0000, 2'b00);
    check("R9 byte write ignored", pinOe, 16'h00FF);
    busRead(8'h08, 16'h0400, "R9 narrow read keeps rdata", 2'b10);
    // R10 read-only and unmapped offsets
    busWrite(8'h00, 16'h0000);
    busRead(8'h00, 16'h0700, "R10 sample write ignored");
    busRead(8'h18, 16'hFFFF, "R10 pen intact");
    busWrite(8'h1C, 16'h0000);
    busWrite(8'h0A, 16'h0000);
    busWrite(8'h28, 16'h0000);
    busRead(8'h08, 16'hFF00, "R10 dir intact");
    busRead(8'h0C, 16'h0F00, "R10 edge intact");
    busRead(8'h10, 16'h0200, "R10 mask intact");
    busRead(8'h1C, 16'h0200, "R10 unmapped read keeps rdata");
    busRead(8'h04, 16'h00A5, "R11 latch readback");
    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin checks++; errors++; $display("FAIL R11 actual pending expected empty"); end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule